// File: doc/BRIEF.md
# Four-Finger RAKE Despread-and-Combine Datapath

This block takes a stream of complex baseband samples, four per chip, and turns them into one combined symbol per spreading period. Every accepted sample is stored in a shared circular history buffer. On each chip sample, four independent fingers each pick one stored sample at their own path delay. Each finger removes the spreading code by multiplying with a chip from {±1±i}. It sums the despread chips over one symbol, then scales the sum by its complex channel weight.

The weighted finger results of the enabled fingers are added into a single complex symbol. That symbol appears with a one-cycle valid strobe. Code chips, path delays and channel weights are supplied from outside by a code generator, a path searcher and a channel estimator. They are held stable while a symbol is in flight. The history depth must be a power of two and the oversampling ratio at least two.

Top module: `rake_combiner`

## Requirements
- R1: Each sample presented with `samp_valid` high is stored at the current write address. That address starts at 0 after reset, advances by one per accepted sample, wraps from 511 to 0, and holds while `samp_valid` is low.
- R2: Every fourth accepted sample after reset (the 4th, 8th, ...) is a chip sample. Cycles with `samp_valid` low do not count. The code bits for all fingers are taken from `code_chip` in the same cycle as the chip sample.
- R3: On a chip sample, finger f uses the stored sample at address (write address of that chip sample − `finger_delay[f]`) mod 512. A delay of 0 selects the chip sample itself. Delays from 0 to 508 samples (127 chips) are supported.
- R4: The despread value is the sample times c = (1 − 2·a) + j(1 − 2·b). Here a is bit 2f of `code_chip` and b is bit 2f+1, and a bit value of 1 means a negative component.
- R5: Each finger sums S despread chips, where S is the `spread_len` value, and then restarts from zero. A value of 0 or 1 closes a symbol on every chip.
- R6: At the end of a symbol, each finger's sum A is multiplied by its weight h = `chan_re[f]` + j`chan_im[f]`, both signed 8-bit, giving A·h.
- R7: The output symbol is the sum of A·h over the fingers whose `finger_en` bit is 1. A disabled finger adds zero, and a mask of all zeros still produces a strobe with a zero symbol.
- R8: `sym_valid` is a single-cycle pulse. It rises on the third rising clock edge after the edge that accepts the final chip sample of a symbol. No pulse occurs otherwise.
- R9: Synchronous reset clears the write address, the sample phase, the chip count, all sums and the output strobe. It leaves the history contents intact, so fingers may read samples stored before the reset.
- R10: Full-scale inputs (samples of −128 or 127, weights of −128, S = 511) produce the exact mathematical result with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | 1 | Sample strobe |
| samp_re | input | 8 | Sample in-phase part, signed |
| samp_im | input | 8 | Sample quadrature part, signed |
| code_chip | input | 8 | Two code sign bits per finger (I at 2f, Q at 2f+1) |
| finger_en | input | 4 | Per-finger enable |
| finger_delay | input | 36 | Per-finger path delay in samples, 9 bits each |
| chan_re | input | 32 | Per-finger weight real part, signed 8 bits each |
| chan_im | input | 32 | Per-finger weight imaginary part, signed 8 bits each |
| spread_len | input | 9 | Chips per symbol |
| sym_valid | output | 1 | Combined symbol strobe |
| sym_re | output | 30 | Combined symbol real part, signed |
| sym_im | output | 30 | Combined symbol imaginary part, signed |

## Verification
A write address off by one shows up in the first symbol that any finger with a nonzero delay completes. That finger then reads the wrong sample, so the error reaches the ports within one symbol period plus three cycles. A sample-phase or chip-count error moves the `sym_valid` strobe, and the bench checks the exact cycle of every strobe. A sum that is not cleared leaks into the next symbol's value, and a swapped code sign or swapped component corrupts the very next output. Each of these errors therefore appears at the ports at the next symbol boundary. The sweeps over code pairs, delays, weights and enable masks make sure that every such path carries data that tells a right result from a wrong one.

// File: rtl/rake_pkg.sv
package rake_pkg;

    localparam int FINGERS    = 4;
    localparam int OVERSAMPLE = 4;
    localparam int SAMPLE_W   = 8;
    localparam int COEF_W     = 8;
    localparam int SF_BITS    = 9;
    localparam int HIST_DEPTH = 512;

    // one code chip: each bit set means that component of the code is -1
    typedef struct packed {
        logic neg_q;
        logic neg_i;
    } chip_t;

    // width of a despread chip: sample width plus sign growth of two adds
    function automatic int despread_width(int samp_w);
        return samp_w + 2;
    endfunction

endpackage

// File: rtl/rake_delay_mem.sv
module rake_delay_mem #(
    parameter int DEPTH = 512,
    parameter int DW    = 16,
    parameter int NR    = 4,
    parameter int AW    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic [NR*AW-1:0]  rd_addr,
    output logic [AW-1:0]     wr_ptr,
    output logic [NR*DW-1:0]  rd_data
);

    logic [DW-1:0] store [DEPTH];

    // history is deliberately not reset: it survives a datapath reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (wr_en) begin
            if (wr_ptr == AW'(DEPTH - 1)) begin
                wr_ptr <= '0;
            end else begin
                wr_ptr <= wr_ptr + AW'(1);
            end
        end
    end

    genvar r;
    generate
        for (r = 0; r < NR; r++) begin : g_port
            assign rd_data[r*DW +: DW] = store[rd_addr[r*AW +: AW]];
        end
    endgenerate

endmodule

// File: rtl/rake_finger.sv
module rake_finger
    import rake_pkg::*;
#(
    parameter int SAMP_W = 8,
    parameter int H_W    = 8,
    parameter int ACC_W  = 19,
    parameter int PROD_W = 28
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic                     last,
    input  logic [2*SAMP_W-1:0]      smp,
    input  chip_t                    code,
    input  logic signed [H_W-1:0]    h_re,
    input  logic signed [H_W-1:0]    h_im,
    output logic signed [PROD_W-1:0] w_re,
    output logic signed [PROD_W-1:0] w_im,
    output logic                     w_valid
);

    localparam int XW = despread_width(SAMP_W);

    logic signed [XW-1:0]     xr, xi;
    logic signed [XW-1:0]     ds_re, ds_im;
    logic signed [ACC_W-1:0]  acc_re, acc_im;
    logic signed [ACC_W-1:0]  nxt_re, nxt_im;
    logic signed [ACC_W-1:0]  dmp_re, dmp_im;
    logic                     dmp_v;
    logic signed [PROD_W-1:0] ar, ai, hr, hi;

    assign xr = XW'($signed(smp[2*SAMP_W-1:SAMP_W]));
    assign xi = XW'($signed(smp[SAMP_W-1:0]));

    // (xr + j xi)(ci + j cq): real = ci*xr - cq*xi, imag = ci*xi + cq*xr
    always_comb begin
        ds_re = (code.neg_i ? -xr : xr) + (code.neg_q ? xi : -xi);
        ds_im = (code.neg_i ? -xi : xi) + (code.neg_q ? -xr : xr);
    end

    assign nxt_re = acc_re + ACC_W'(ds_re);
    assign nxt_im = acc_im + ACC_W'(ds_im);

    // integrate and dump
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_re <= '0;
            acc_im <= '0;
            dmp_re <= '0;
            dmp_im <= '0;
            dmp_v  <= 1'b0;
        end else begin
            dmp_v <= tick && last;
            if (tick) begin
                if (last) begin
                    dmp_re <= nxt_re;
                    dmp_im <= nxt_im;
                    acc_re <= '0;
                    acc_im <= '0;
                end else begin
                    acc_re <= nxt_re;
                    acc_im <= nxt_im;
                end
            end
        end
    end

    assign ar = PROD_W'(dmp_re);
    assign ai = PROD_W'(dmp_im);
    assign hr = PROD_W'(h_re);
    assign hi = PROD_W'(h_im);

    // channel weighting
    always_ff @(posedge clk) begin
        if (rst) begin
            w_re    <= '0;
            w_im    <= '0;
            w_valid <= 1'b0;
        end else begin
            w_valid <= dmp_v;
            if (dmp_v) begin
                w_re <= ar * hr - ai * hi;
                w_im <= ar * hi + ai * hr;
            end
        end
    end

endmodule

// File: rtl/rake_sum.sv
module rake_sum #(
    parameter int NF     = 4,
    parameter int PROD_W = 28,
    parameter int OUT_W  = 30
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NF*PROD_W-1:0]    w_re_v,
    input  logic [NF*PROD_W-1:0]    w_im_v,
    input  logic [NF-1:0]           w_valid,
    input  logic [NF-1:0]           en,
    output logic                    sym_valid,
    output logic signed [OUT_W-1:0] sym_re,
    output logic signed [OUT_W-1:0] sym_im
);

    logic signed [OUT_W-1:0] tot_re, tot_im;
    logic                    all_v;

    assign all_v = &w_valid;

    always_comb begin
        tot_re = '0;
        tot_im = '0;
        for (int f = 0; f < NF; f++) begin
            if (en[f]) begin
                tot_re = tot_re + OUT_W'($signed(w_re_v[f*PROD_W +: PROD_W]));
                tot_im = tot_im + OUT_W'($signed(w_im_v[f*PROD_W +: PROD_W]));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_valid <= 1'b0;
            sym_re    <= '0;
            sym_im    <= '0;
        end else begin
            sym_valid <= all_v;
            if (all_v) begin
                sym_re <= tot_re;
                sym_im <= tot_im;
            end
        end
    end

endmodule

// File: rtl/rake_combiner.sv
module rake_combiner
    import rake_pkg::*;
#(
    parameter int NF     = FINGERS,
    parameter int OSR    = OVERSAMPLE,
    parameter int SAMP_W = SAMPLE_W,
    parameter int H_W    = COEF_W,
    parameter int SF_W   = SF_BITS,
    parameter int DEPTH  = HIST_DEPTH,
    parameter int AW     = $clog2(DEPTH),
    parameter int OUT_W  = despread_width(SAMP_W) + SF_W + H_W + 1 + $clog2(NF)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    samp_valid,
    input  logic signed [SAMP_W-1:0] samp_re,
    input  logic signed [SAMP_W-1:0] samp_im,
    input  logic [2*NF-1:0]         code_chip,
    input  logic [NF-1:0]           finger_en,
    input  logic [NF*AW-1:0]        finger_delay,
    input  logic [NF*H_W-1:0]       chan_re,
    input  logic [NF*H_W-1:0]       chan_im,
    input  logic [SF_W-1:0]         spread_len,
    output logic                    sym_valid,
    output logic signed [OUT_W-1:0] sym_re,
    output logic signed [OUT_W-1:0] sym_im
);

    localparam int DW     = 2 * SAMP_W;
    localparam int PH_W   = $clog2(OSR);
    localparam int ACC_W  = despread_width(SAMP_W) + SF_W;
    localparam int PROD_W = ACC_W + H_W + 1;

    logic [PH_W-1:0]      phase;
    logic [SF_W-1:0]      chip_cnt;
    logic                 chip_stb, last_chip;
    logic                 tick_q, last_q;
    logic [AW-1:0]        wptr, wp_q;
    logic [2*NF-1:0]      code_q;
    logic [NF*AW-1:0]     rd_addr;
    logic [NF*DW-1:0]     rd_data;
    logic [NF*PROD_W-1:0] w_re_v, w_im_v;
    logic [NF-1:0]        w_valid;

    assign chip_stb  = samp_valid && (phase == PH_W'(OSR - 1));
    assign last_chip = ({1'b0, chip_cnt} + (SF_W+1)'(1)) >= {1'b0, spread_len};

    // sample phase, chip count and chip-sample capture
    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            chip_cnt <= '0;
            tick_q   <= 1'b0;
            last_q   <= 1'b0;
            wp_q     <= '0;
            code_q   <= '0;
        end else begin
            tick_q <= chip_stb;
            last_q <= chip_stb && last_chip;
            if (samp_valid) begin
                phase <= (phase == PH_W'(OSR - 1)) ? '0 : phase + PH_W'(1);
            end
            if (chip_stb) begin
                wp_q     <= wptr;
                code_q   <= code_chip;
                chip_cnt <= last_chip ? '0 : chip_cnt + SF_W'(1);
            end
        end
    end

    rake_delay_mem #(
        .DEPTH (DEPTH),
        .DW    (DW),
        .NR    (NF),
        .AW    (AW)
    ) u_hist (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (samp_valid),
        .wr_data ({samp_re, samp_im}),
        .rd_addr (rd_addr),
        .wr_ptr  (wptr),
        .rd_data (rd_data)
    );

    genvar f;
    generate
        for (f = 0; f < NF; f++) begin : g_finger
            assign rd_addr[f*AW +: AW] = wp_q - finger_delay[f*AW +: AW];

            rake_finger #(
                .SAMP_W (SAMP_W),
                .H_W    (H_W),
                .ACC_W  (ACC_W),
                .PROD_W (PROD_W)
            ) u_finger (
                .clk     (clk),
                .rst     (rst),
                .tick    (tick_q),
                .last    (last_q),
                .smp     (rd_data[f*DW +: DW]),
                .code    (chip_t'(code_q[2*f +: 2])),
                .h_re    (chan_re[f*H_W +: H_W]),
                .h_im    (chan_im[f*H_W +: H_W]),
                .w_re    (w_re_v[f*PROD_W +: PROD_W]),
                .w_im    (w_im_v[f*PROD_W +: PROD_W]),
                .w_valid (w_valid[f])
            );
        end
    endgenerate

    rake_sum #(
        .NF     (NF),
        .PROD_W (PROD_W),
        .OUT_W  (OUT_W)
    ) u_sum (
        .clk       (clk),
        .rst       (rst),
        .w_re_v    (w_re_v),
        .w_im_v    (w_im_v),
        .w_valid   (w_valid),
        .en        (finger_en),
        .sym_valid (sym_valid),
        .sym_re    (sym_re),
        .sym_im    (sym_im)
    );

endmodule

// File: rtl/rake_combiner_chk.sv
module rake_combiner_chk #(
    parameter int NF    = 4,
    parameter int AW    = 9,
    parameter int OUT_W = 30
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    samp_valid,
    input logic [NF-1:0]           finger_en,
    input logic                    sym_valid,
    input logic signed [OUT_W-1:0] sym_re,
    input logic signed [OUT_W-1:0] sym_im,
    input logic [AW-1:0]           wptr,
    input logic                    last_q
);

    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (!sym_valid && wptr == '0));

    assert_wptr_step_R1: assert property (@(posedge clk) disable iff (rst)
        samp_valid |=> (wptr == $past(wptr) + AW'(1)));

    assert_wptr_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !samp_valid |=> $stable(wptr));

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        last_q |-> ##3 sym_valid);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> !sym_valid);

    assert_strobe_source_R8: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> $past(last_q, 3));

    assert_masked_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && $past(finger_en) == '0) |-> (sym_re == '0 && sym_im == '0));

endmodule

bind rake_combiner rake_combiner_chk #(
    .NF    (NF),
    .AW    (AW),
    .OUT_W (OUT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .samp_valid (samp_valid),
    .finger_en  (finger_en),
    .sym_valid  (sym_valid),
    .sym_re     (sym_re),
    .sym_im     (sym_im),
    .wptr       (wptr),
    .last_q     (last_q)
);

// File: tb/sim_rake_combiner.sv
`timescale 1ns/1ps
module sim_rake_combiner;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               samp_valid = 1'b0;
    logic signed [7:0]  samp_re = '0;
    logic signed [7:0]  samp_im = '0;
    logic [7:0]         code_chip = '0;
    logic [3:0]         finger_en = '0;
    logic [35:0]        finger_delay = '0;
    logic [31:0]        chan_re = '0;
    logic [31:0]        chan_im = '0;
    logic [8:0]         spread_len = 9'd1;
    logic               sym_valid;
    logic signed [29:0] sym_re, sym_im;

    rake_combiner u0 (
        .clk(clk), .rst(rst), .samp_valid(samp_valid),
        .samp_re(samp_re), .samp_im(samp_im), .code_chip(code_chip),
        .finger_en(finger_en), .finger_delay(finger_delay),
        .chan_re(chan_re), .chan_im(chan_im), .spread_len(spread_len),
        .sym_valid(sym_valid), .sym_re(sym_re), .sym_im(sym_im)
    );

    always #10 clk = ~clk;

    int     nchk = 0, nerr = 0, cyc = 0;
    bit     chk_en = 1'b0, done = 1'b0;
    string  cur_tag = "R3";

    // requirement model state
    int     mem_re [512];
    int     mem_im [512];
    int     wp_m = 0, phase_m = 0, chip_m = 0;
    longint acc_r [4];
    longint acc_i [4];
    longint q_re [$];
    longint q_im [$];
    int     q_cyc [$];
    string  q_tag [$];

    task automatic model_clear();
        wp_m = 0; phase_m = 0; chip_m = 0;
        for (int f = 0; f < 4; f++) begin acc_r[f] = 0; acc_i[f] = 0; end
    endtask

    task automatic model_accept(int re, int im, logic [7:0] cc);
        mem_re[wp_m] = re;
        mem_im[wp_m] = im;
        if (phase_m == 3) begin
            bit     last;
            longint sr, si;
            last = (chip_m + 1) >= int'(spread_len);
            sr = 0; si = 0;
            for (int f = 0; f < 4; f++) begin
                int a, ci, cq, xr, xi;
                a  = (wp_m - int'(finger_delay[f*9 +: 9]) + 512) % 512;
                xr = mem_re[a];
                xi = mem_im[a];
                ci = cc[2*f] ? -1 : 1;
                cq = cc[2*f+1] ? -1 : 1;
                acc_r[f] += ci * xr - cq * xi;
                acc_i[f] += ci * xi + cq * xr;
                if (last) begin
                    longint hr, hi;
                    hr = longint'($signed(chan_re[f*8 +: 8]));
                    hi = longint'($signed(chan_im[f*8 +: 8]));
                    if (finger_en[f]) begin
                        sr += acc_r[f] * hr - acc_i[f] * hi;
                        si += acc_r[f] * hi + acc_i[f] * hr;
                    end
                    acc_r[f] = 0;
                    acc_i[f] = 0;
                end
            end
            if (last) begin
                if (chk_en) begin
                    q_re.push_back(sr);
                    q_im.push_back(si);
                    q_cyc.push_back(cyc + 4);
                    q_tag.push_back(cur_tag);
                end
                chip_m = 0;
            end else begin
                chip_m = chip_m + 1;
            end
        end
        phase_m = (phase_m + 1) % 4;
        wp_m    = (wp_m + 1) % 512;
    endtask

    task automatic check_out();
        if (!chk_en) return;
        if (sym_valid) begin
            nchk++;
            if (q_cyc.size() == 0 || q_cyc[0] != cyc) begin
                nerr++;
                $display("FAIL R8: strobe at cycle %0d, expected cycle %0d",
                         cyc, (q_cyc.size() == 0) ? -1 : q_cyc[0]);
                if (q_cyc.size() != 0 && q_cyc[0] < cyc) begin
                    void'(q_re.pop_front()); void'(q_im.pop_front());
                    void'(q_cyc.pop_front()); void'(q_tag.pop_front());
                end
            end else begin
                if (longint'(sym_re) != q_re[0] || longint'(sym_im) != q_im[0]) begin
                    nerr++;
                    $display("FAIL %s: symbol got (%0d,%0d) expected (%0d,%0d)",
                             q_tag[0], longint'(sym_re), longint'(sym_im), q_re[0], q_im[0]);
                end
                void'(q_re.pop_front()); void'(q_im.pop_front());
                void'(q_cyc.pop_front()); void'(q_tag.pop_front());
            end
        end else if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
            nchk++; nerr++;
            $display("FAIL R8: no strobe at cycle %0d, expected strobe (%s)", cyc, q_tag[0]);
            void'(q_re.pop_front()); void'(q_im.pop_front());
            void'(q_cyc.pop_front()); void'(q_tag.pop_front());
        end
    endtask

    task automatic step(bit v, int re, int im, logic [7:0] cc);
        @(negedge clk);
        cyc++;
        check_out();
        samp_valid = v;
        samp_re    = 8'(re);
        samp_im    = 8'(im);
        code_chip  = cc;
        if (v) model_accept(re, im, cc);
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) step(1'b0, 0, 0, 8'h00);
    endtask

    // R9: reset clears datapath state; history contents are kept
    task automatic do_reset();
        @(negedge clk); cyc++;
        rst = 1'b1; samp_valid = 1'b0;
        @(negedge clk); cyc++;
        @(negedge clk); cyc++;
        rst = 1'b0;
        model_clear();
        nchk++;
        if (sym_valid !== 1'b0 || sym_re !== '0 || sym_im !== '0) begin
            nerr++;
            $display("FAIL R9: after reset valid=%0b re=%0d im=%0d expected 0,0,0",
                     sym_valid, sym_re, sym_im);
        end
    endtask

    // mode 0 random, 1 full-scale negative, 2 full-scale positive, 3 code sweep
    task automatic run(int n, int gap_pct, int mode);
        for (int k = 0; k < n; k++) begin
            bit v;
            int re, im;
            logic [7:0] cc;
            v  = (gap_pct == 0) || (($urandom % 100) >= gap_pct);
            re = $signed(8'($urandom));
            im = $signed(8'($urandom));
            cc = 8'($urandom);
            if (mode == 1) begin re = -128; im = -128; cc = 8'h55; end
            if (mode == 2) begin re = 127;  im = 127;  cc = 8'hAA; end
            if (mode == 3) cc = 8'(k / 4);
            step(v, re, im, cc);
        end
    endtask

    task automatic set_delays(int d0, int d1, int d2, int d3);
        finger_delay = {9'(d3), 9'(d2), 9'(d1), 9'(d0)};
    endtask

    task automatic set_all_h(int hr, int hi);
        for (int f = 0; f < 4; f++) begin
            chan_re[f*8 +: 8] = 8'(hr + f);
            chan_im[f*8 +: 8] = 8'(hi - f);
        end
    endtask

    initial begin
        int hv [6] = '{-128, -1, 0, 1, 37, 127};
        int dv [12] = '{0, 1, 2, 3, 4, 127, 128, 255, 256, 400, 507, 508};
        int sv [6] = '{0, 1, 2, 3, 5, 16};

        model_clear();
        for (int a = 0; a < 512; a++) begin mem_re[a] = 0; mem_im[a] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // prime the whole history so every address holds a known sample
        finger_en = 4'hF; spread_len = 9'd1; set_delays(0, 0, 0, 0); set_all_h(1, 0);
        run(600, 0, 0);
        drain();
        chk_en = 1'b1;
        do_reset();

        // R4: all 256 joint code combinations across the four fingers
        cur_tag = "R4";
        set_delays(0, 5, 17, 33); set_all_h(3, 2); finger_en = 4'hF; spread_len = 9'd1;
        run(1024, 0, 3);
        drain();

        // R3: delay sweep on a single finger, then mixed boundary delays
        cur_tag = "R3";
        finger_en = 4'b0001; spread_len = 9'd2;
        for (int i = 0; i < 12; i++) begin
            set_delays(dv[i], 0, 0, 0);
            run(64, 0, 0);
            drain();
        end
        finger_en = 4'hF; set_delays(508, 0, 3, 252);
        run(128, 0, 0);
        drain();

        // R5 spread lengths, then R2 chip counting across gaps
        for (int g = 0; g < 2; g++) begin
            cur_tag = (g == 0) ? "R5" : "R2";
            set_delays(1, 9, 40, 200);
            for (int i = 0; i < 6; i++) begin
                int s;
                s = (sv[i] < 1) ? 1 : sv[i];
                do_reset();
                spread_len = 9'(sv[i]);
                run(16 * s * ((g == 0) ? 1 : 2), (g == 0) ? 0 : 35, 0);
                drain();
            end
        end

        // R6: channel weight sweep
        cur_tag = "R6";
        do_reset();
        spread_len = 9'd4; set_delays(2, 6, 11, 100);
        for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 6; b++) begin
                for (int f = 0; f < 4; f++) begin
                    chan_re[f*8 +: 8] = 8'(hv[(a + f) % 6]);
                    chan_im[f*8 +: 8] = 8'(hv[(b + 3 * f) % 6]);
                end
                run(16, 0, 0);
                drain();
            end
        end

        // R7: every enable mask, including none
        cur_tag = "R7";
        set_all_h(5, -7); spread_len = 9'd3;
        for (int m = 0; m < 16; m++) begin
            finger_en = 4'(m);
            run(24, 0, 0);
            drain();
        end

        // R10: full-scale accumulation over the longest symbol
        cur_tag = "R10";
        finger_en = 4'hF; set_delays(0, 4, 8, 12); spread_len = 9'd511;
        for (int f = 0; f < 4; f++) begin chan_re[f*8 +: 8] = 8'h80; chan_im[f*8 +: 8] = 8'h80; end
        do_reset();
        run(2044, 0, 1);
        drain();
        do_reset();
        run(2044, 0, 2);
        drain();

        // R9: reset in the middle of a symbol; history read across the reset
        cur_tag = "R9";
        set_all_h(9, 4); spread_len = 9'd8; set_delays(300, 0, 100, 508);
        do_reset();
        run(13, 0, 0);
        drain();
        do_reset();
        run(64, 0, 0);
        drain();

        // R1: long run wrapping the write address with small delays
        cur_tag = "R1";
        spread_len = 9'd1; set_delays(4, 8, 12, 16);
        run(700, 20, 0);
        drain();

        if (q_cyc.size() != 0) begin
            nchk++; nerr++;
            $display("FAIL R8: %0d symbols never appeared, expected 0", q_cyc.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R8: watchdog expired, got hang, expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule